// File: doc/BRIEF.md
# Dual-Mode Correction-Term Multiplier

This block multiplies two 8-bit integers and returns a 16-bit product. A mode input chooses whether the operands are read as unsigned or as two's-complement values. The block never sign-extends its inputs. It always forms the plain unsigned product of the two raw bit patterns. In signed mode it then adds a correction into the upper half of that product for each negative operand. Each correction is the other operand negated by complement-plus-one and moved up by the operand width, which costs only wiring.

A single register stage holds the result. When an operand pair arrives with its valid strobe, the product and an output valid appear one clock later. The registered product keeps its value on cycles without a valid strobe.

Top module: `corr_mul`

## Requirements
- R1: With `signedMode` low, a valid operand pair yields the unsigned product `opA*opB` (modulo 2^16) on `product`. A pair where either operand is zero yields 0.
- R2: With `signedMode` high, a valid operand pair yields the 16-bit two's-complement product of the operands read as signed 8-bit values.
- R3: In signed mode, a negative operand (bit 7 set) contributes the negation of the other operand, shifted left by 8, to the upper byte. For example, 0x80 × 0x01 gives 0xFF80.
- R4: When both operands are negative, both corrections apply. For example, 0x80 × 0x80 in signed mode gives 0x4000.
- R5: In unsigned mode the operands' top bits cause no correction. For example, 0xFF × 0xFF gives 0xFE01.
- R6: `outValid` is high in the cycle after a clock edge that sampled `inValid` high, and low after one that sampled it low.
- R7: A clock edge that samples `inValid` low leaves `product` unchanged.
- R8: A clock edge that samples `rst` high clears both `outValid` and `product`. Reset is synchronous and active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operand pair present this cycle |
| signedMode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| outValid | output | 1 | Product register holds a fresh result |
| product | output | 16 | Registered 16-bit product |

## Verification
The product and the output valid are both due exactly one rising edge after the operands are sampled. Reset clearing and holding on idle cycles show up at that same edge. The bench drives every stimulus at a falling edge and compares at the next falling edge. There, a behavioural model built from integers predicts the state the register should hold after the rising edge in between. All 65,536 operand pairs are applied back to back in each mode. Idle gaps and a reset in mid-stream check the hold and clear behaviour at the same single-cycle offset.

// File: rtl/corr_mul_pkg.sv
package corr_mul_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new product
    logic clear;  // zero the product register
  } mulStrobes_t;

endpackage

// File: rtl/corr_mul_ctrl.sv
module corr_mul_ctrl
  import corr_mul_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output mulStrobes_t strobes,
  output logic        outValid
);

  always_comb begin
    strobes.clear = rst;
    strobes.load  = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R6: output valid follows the input strobe by one cycle
  p_valid_rise_r6: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  p_valid_fall_r6: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/corr_mul_dp.sv
module corr_mul_dp
  import corr_mul_pkg::*;
#(
  parameter int WIDTH = 8
)(
  input  logic               clk,
  input  mulStrobes_t        strobes,
  input  logic               signedMode,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2*WIDTH-1:0] product
);

  localparam int PW  = 2 * WIDTH;
  localparam int MSB = WIDTH - 1;

  logic [PW-1:0]    baseProd;
  logic [WIDTH-1:0] ops     [2];
  logic [WIDTH-1:0] corrTerm[2];
  logic [WIDTH-1:0] hiSum;
  logic [PW-1:0]    result;

  assign ops[0]   = opA;
  assign ops[1]   = opB;
  assign baseProd = {{WIDTH{1'b0}}, opA} * {{WIDTH{1'b0}}, opB};

  // One correction per operand: a negative operand adds the negated partner
  for (genvar i = 0; i < 2; i++) begin : g_corr
    always_comb begin
      if (signedMode && ops[i][MSB])
        corrTerm[i] = ~ops[1-i] + WIDTH'(1);
      else
        corrTerm[i] = '0;
    end
  end

  // Shift by WIDTH is wiring: the corrections land only in the upper half
  assign hiSum  = baseProd[PW-1:WIDTH] + corrTerm[0] + corrTerm[1];
  assign result = {hiSum, baseProd[WIDTH-1:0]};

  always_ff @(posedge clk) begin
    if (strobes.clear)     product <= '0;
    else if (strobes.load) product <= result;
  end

  // R1: a zero operand gives a zero product in either mode
  p_zero_operand_r1: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.load && (opA == '0 || opB == '0) |=> product == '0);

  // R5: unsigned mode leaves the upper half of the raw product untouched
  p_unsigned_plain_r5: assert property (@(posedge clk) disable iff (strobes.clear)
    !signedMode |-> hiSum == baseProd[PW-1:WIDTH]);

  // R7: no load, no change
  p_hold_r7: assert property (@(posedge clk)
    !strobes.load && !strobes.clear |=> $stable(product));

  // R8: clear empties the register
  p_clear_r8: assert property (@(posedge clk)
    strobes.clear |=> product == '0);

endmodule

// File: rtl/corr_mul.sv
module corr_mul
  import corr_mul_pkg::*;
#(
  parameter int WIDTH = 8
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic               signedMode,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic               outValid,
  output logic [2*WIDTH-1:0] product
);

  mulStrobes_t strobes;

  corr_mul_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  corr_mul_dp #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .strobes    (strobes),
    .signedMode (signedMode),
    .opA        (opA),
    .opB        (opB),
    .product    (product)
  );

endmodule

// File: tb/tb_corr_mul.sv
module tb_corr_mul;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        signedMode = 1'b0;
  logic [7:0]  opA = '0;
  logic [7:0]  opB = '0;
  logic        outValid;
  logic [15:0] product;

  int checks = 0;
  int failures = 0;
  bit armed = 0;
  logic        expValid;
  logic [15:0] expProd;
  string       expTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  corr_mul dut (
    .clk(clk), .rst(rst), .inValid(inValid), .signedMode(signedMode),
    .opA(opA), .opB(opB), .outValid(outValid), .product(product)
  );

  function automatic logic [15:0] refMul(input logic m, input logic [7:0] a,
                                         input logic [7:0] b);
    int ia, ib, p;
    ia = m ? int'($signed(a)) : int'(a);
    ib = m ? int'($signed(b)) : int'(b);
    p  = ia * ib;
    return p[15:0];
  endfunction

  task automatic compareNow();
    if (!armed) return;
    checks++;
    if (outValid !== expValid) begin
      failures++;
      $display("FAIL R6 outValid actual=%0b expected=%0b (%s)", outValid, expValid, expTag);
    end
    checks++;
    if (product !== expProd) begin
      failures++;
      $display("FAIL %s product actual=%04h expected=%04h", expTag, product, expProd);
    end
  endtask

  // Check the previous prediction, then drive the next stimulus and predict
  task automatic step(input logic r, input logic v, input logic m,
                      input logic [7:0] a, input logic [7:0] b, input string tag);
    @(negedge clk);
    compareNow();
    rst = r; inValid = v; signedMode = m; opA = a; opB = b;
    if (r) begin
      expValid = 1'b0; expProd = '0; expTag = "R8";
    end else begin
      expValid = v;
      if (v) begin
        expProd = refMul(m, a, b);
        expTag  = tag;
      end else begin
        expTag  = "R7";
      end
    end
    armed = 1;
  endtask

  initial begin
    step(1, 0, 0, 8'h00, 8'h00, "R8");
    step(1, 1, 1, 8'h12, 8'h34, "R8");
    step(0, 0, 0, 8'h00, 8'h00, "R8");   // reset state observed here
    // Corner cases
    step(0, 1, 1, 8'h80, 8'h80, "R4");   // 0x4000
    step(0, 1, 1, 8'h80, 8'h01, "R3");   // 0xFF80
    step(0, 1, 1, 8'h01, 8'h80, "R3");
    step(0, 1, 0, 8'hFF, 8'hFF, "R5");   // 0xFE01
    step(0, 1, 1, 8'hFF, 8'hFF, "R4");   // 0x0001
    step(0, 1, 0, 8'h80, 8'h80, "R5");   // 0x4000 unsigned too
    step(0, 1, 0, 8'h00, 8'hC3, "R1");
    // Idle cycles must hold the last product
    step(0, 0, 1, 8'h7F, 8'h7F, "R7");
    step(0, 0, 0, 8'h11, 8'h22, "R7");
    // Exhaustive sweep in both modes
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          step(0, 1, m[0], a[7:0], b[7:0], m ? "R2" : "R1");
    // Gaps and a mid-stream reset
    step(0, 1, 1, 8'h9C, 8'h37, "R2");
    step(0, 0, 0, 8'h00, 8'h00, "R7");
    step(1, 1, 0, 8'hAA, 8'h55, "R8");
    step(0, 0, 0, 8'hAA, 8'h55, "R8");
    step(0, 1, 1, 8'h7F, 8'h81, "R3");
    step(0, 0, 0, 8'h00, 8'h00, "R7");
    @(negedge clk);
    compareNow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule